// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer and Refresh Debt Tracker

This block drives the command pins of a single-rank x16 SDRAM on behalf of a larger memory controller. After a one-cycle start pulse it plays a fixed power-up script. The script closes all banks with a precharge-all, loads the mode register, runs two auto-refresh commands, and then enables the device for normal work. Each command waits a programmable number of cycles after the one before it.

Once the device is enabled, a free-running interval timer adds one owed refresh each period. The block asks the external bus arbiter for the memory bus while any refresh is owed. When the arbiter grants the bus, it issues an auto-refresh, which pays back one owed period. An urgency flag rises when the debt reaches half of a programmable limit. A sticky error flag is set once the debt goes past that limit. A registered address splitter turns a linear word address into bank, row and column fields, for either a 4M x16 device with 8 column bits or an 8M x16 device with 9 column bits.

Top module: `sdram_init_refresh_ctrl`

## Requirements
- R1: After reset the command pins hold NOP, and init_done, ref_req, ref_urgent, lag_err and owed_count are all zero. Commands are coded as {cs_n,ras_n,cas_n,we_n}: NOP=0111, precharge=0010, mode-register-set=0000, auto-refresh=0001.
- R2: A pulse on init_start while idle produces, in this order, precharge-all with cmd_addr bit 10 set (cmd_addr=0x400), mode-register-set with cmd_addr equal to mode_word and bank bits 13:12 zero, auto-refresh, and auto-refresh. After that, init_done rises and stays high.
- R3: The mode-register-set appears t_rp cycles after the precharge. The first refresh appears t_mrd cycles after the mode-register-set. The second refresh appears t_rfc cycles after the first. init_done rises t_rfc cycles after the second refresh. A delay value of 0 acts as 1.
- R4: init_start is ignored while the sequence is running and after it has finished.
- R5: Before init_done is high, no refresh debt accrues: owed_count stays 0 and ref_req stays low.
- R6: After init_done, with no grants, owed_count rises by one every refresh_interval cycles.
- R7: ref_req is high when owed_count is nonzero and no refresh is in recovery. A grant in such a cycle puts an auto-refresh on the pins in the next cycle and lowers owed_count by one. A grant while ref_req is low leaves NOP on the pins and owed_count unchanged.
- R8: Two granted refreshes are at least t_rfc cycles apart, and ref_req is low in the cycle after a refresh while recovery runs.
- R9: When an interval tick and a granted refresh fall in the same cycle, owed_count is unchanged and the refresh is still issued.
- R10: ref_urgent is high exactly when owed_count is nonzero and 2*owed_count >= lag_limit.
- R11: lag_err is set one cycle after owed_count exceeds lag_limit. It then stays set, even after the debt is repaid, until reset.
- R12: map_bank/map_row/map_col are registered, one cycle after lin_addr. With wide_col=0: col=lin_addr[7:0] (map_col[8]=0), row=lin_addr[19:8], bank=lin_addr[21:20], and bit 22 is ignored. With wide_col=1: col=lin_addr[8:0], row=lin_addr[20:9], bank=lin_addr[22:21].
- R13: owed_count saturates at 255 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_start | input | 1 | One-cycle pulse that starts the power-up script |
| mode_word | input | 12 | Value driven on the address pins with mode-register-set |
| t_rp | input | 8 | Cycles from precharge to the next command |
| t_mrd | input | 8 | Cycles from mode-register-set to the next command |
| t_rfc | input | 8 | Cycles from an auto-refresh to the next command or refresh |
| refresh_interval | input | 16 | Cycles per owed refresh period |
| lag_limit | input | 8 | Largest debt allowed before the error |
| ref_grant | input | 1 | Bus granted to the refresh engine this cycle |
| wide_col | input | 1 | 0: 8 column bits, 1: 9 column bits |
| lin_addr | input | 23 | Linear word address to split |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | 14 | Address pins: 11:0 row/mode, 13:12 bank |
| init_done | output | 1 | Power-up script finished |
| ref_req | output | 1 | Refresh engine requests the bus |
| ref_urgent | output | 1 | Debt reached half of the limit |
| lag_err | output | 1 | Sticky debt-over-limit error |
| owed_count | output | 8 | Current refresh debt |
| map_bank | output | 2 | Bank field of lin_addr |
| map_row | output | 12 | Row field of lin_addr |
| map_col | output | 9 | Column field of lin_addr |

## Verification
The interval timer adding one period of debt and a granted refresh paying one back can land on the same clock edge. The net debt must then stay where it was, while the refresh still reaches the pins. The bench provokes this case by watching for one debt increment and then counting exactly one interval forward. It raises the grant in the single cycle that the next tick falls in, and judges the result by the auto-refresh code on the pins and an unchanged owed_count in the next cycle.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_MRS, ST_REF1, ST_REF2, ST_ENA, ST_RUN
  } init_st_e;
endpackage

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
  import sdr_ctrl_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DLY_W-1:0] t_rp,
  input  logic [DLY_W-1:0] t_mrd,
  input  logic [DLY_W-1:0] t_rfc,
  output logic             issue,
  output sdr_cmd_e         issue_cmd,
  output logic             init_done
);
  init_st_e         st;
  logic [DLY_W-1:0] cnt;

  function automatic logic [DLY_W-1:0] wait_m1(input logic [DLY_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_comb begin
    issue     = 1'b0;
    issue_cmd = CMD_NOP;
    if (cnt == '0) begin
      case (st)
        ST_PRE:  begin issue = 1'b1; issue_cmd = CMD_PRE; end
        ST_MRS:  begin issue = 1'b1; issue_cmd = CMD_MRS; end
        ST_REF1: begin issue = 1'b1; issue_cmd = CMD_REF; end
        ST_REF2: begin issue = 1'b1; issue_cmd = CMD_REF; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      init_done <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_PRE;
          cnt <= '0;
        end
        ST_RUN: ;
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            case (st)
              ST_PRE:  begin cnt <= wait_m1(t_rp);  st <= ST_MRS;  end
              ST_MRS:  begin cnt <= wait_m1(t_mrd); st <= ST_REF1; end
              ST_REF1: begin cnt <= wait_m1(t_rfc); st <= ST_REF2; end
              ST_REF2: begin cnt <= wait_m1(t_rfc); st <= ST_ENA;  end
              default: begin init_done <= 1'b1;     st <= ST_RUN;  end
            endcase
          end
        end
      endcase
    end
  end

  // R4: once finished the script never restarts
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done) else $error("init_done dropped");

  // R2: script commands are only issued before enable
  assert_no_script_after_done_R2: assert property (@(posedge clk) disable iff (rst)
    issue |-> !init_done) else $error("script command after enable");
endmodule

// File: rtl/sdr_refresh_track.sv
module sdr_refresh_track #(
  parameter int IVL_W  = 16,
  parameter int OWED_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [IVL_W-1:0]  interval,
  input  logic [OWED_W-1:0] lag_limit,
  input  logic [DLY_W-1:0]  t_rfc,
  input  logic              grant,
  output logic              req,
  output logic              urgent,
  output logic              fire,
  output logic [OWED_W-1:0] owed,
  output logic              lag_err
);
  localparam logic [OWED_W-1:0] OWED_MAX = {OWED_W{1'b1}};

  logic [IVL_W-1:0] tick_cnt;
  logic [IVL_W-1:0] ivl_m1;
  logic [DLY_W-1:0] rec_cnt;
  logic             tick;

  assign ivl_m1 = (interval == '0) ? '0 : interval - 1'b1;
  assign tick   = enable && (tick_cnt >= ivl_m1);
  assign req    = enable && (owed != '0) && (rec_cnt == '0);
  assign fire   = req && grant;
  assign urgent = (owed != '0) && ({owed, 1'b0} >= {1'b0, lag_limit});

  always_ff @(posedge clk) begin
    if (rst || !enable) tick_cnt <= '0;
    else if (tick)      tick_cnt <= '0;
    else                tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          rec_cnt <= '0;
    else if (fire)    rec_cnt <= (t_rfc == '0) ? '0 : t_rfc - 1'b1;
    else if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed    <= '0;
      lag_err <= 1'b0;
    end else begin
      case ({tick, fire})
        2'b10:   if (owed != OWED_MAX) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: ;
      endcase
      lag_err <= lag_err | (owed > lag_limit);
    end
  end

  // R6: debt moves by at most one per cycle
  assert_owed_step_R6: assert property (@(posedge clk) disable iff (rst)
    (owed != $past(owed)) |-> ((owed == $past(owed) + 1'b1) || (owed == $past(owed) - 1'b1)))
    else $error("owed jumped");

  // R11: lag error is sticky
  assert_lag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    lag_err |=> lag_err) else $error("lag_err cleared");

  // R8: no back-to-back refreshes when recovery is longer than one cycle
  assert_recovery_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && (t_rfc > 1)) |=> !fire) else $error("refresh during recovery");
endmodule

// File: rtl/sdr_addr_map.sv
module sdr_addr_map #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int NCOL_W = 8,
  localparam int WCOL_W = NCOL_W + 1,
  localparam int ADDR_W = BANK_W + ROW_W + WCOL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_col,
  input  logic [ADDR_W-1:0] lin_addr,
  output logic [BANK_W-1:0] map_bank,
  output logic [ROW_W-1:0]  map_row,
  output logic [WCOL_W-1:0] map_col
);
  always_ff @(posedge clk) begin
    if (rst) begin
      map_bank <= '0;
      map_row  <= '0;
      map_col  <= '0;
    end else if (wide_col) begin
      map_col  <= lin_addr[WCOL_W-1:0];
      map_row  <= lin_addr[WCOL_W +: ROW_W];
      map_bank <= lin_addr[WCOL_W+ROW_W +: BANK_W];
    end else begin
      map_col  <= {1'b0, lin_addr[NCOL_W-1:0]};
      map_row  <= lin_addr[NCOL_W +: ROW_W];
      map_bank <= lin_addr[NCOL_W+ROW_W +: BANK_W];
    end
  end

  // R12: narrow devices never see the top column bit
  assert_narrow_col_R12: assert property (@(posedge clk) disable iff (rst)
    !wide_col |=> (map_col[NCOL_W] == 1'b0)) else $error("narrow column overflow");
endmodule

// File: rtl/sdram_init_refresh_ctrl.sv
module sdram_init_refresh_ctrl
  import sdr_ctrl_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int NCOL_W = 8,
  parameter int DLY_W  = 8,
  parameter int IVL_W  = 16,
  parameter int OWED_W = 8,
  parameter int AP_BIT = 10,
  localparam int CA_W   = ROW_W + BANK_W,
  localparam int WCOL_W = NCOL_W + 1,
  localparam int ADDR_W = BANK_W + ROW_W + WCOL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_start,
  input  logic [ROW_W-1:0]  mode_word,
  input  logic [DLY_W-1:0]  t_rp,
  input  logic [DLY_W-1:0]  t_mrd,
  input  logic [DLY_W-1:0]  t_rfc,
  input  logic [IVL_W-1:0]  refresh_interval,
  input  logic [OWED_W-1:0] lag_limit,
  input  logic              ref_grant,
  input  logic              wide_col,
  input  logic [ADDR_W-1:0] lin_addr,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [CA_W-1:0]   cmd_addr,
  output logic              init_done,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              lag_err,
  output logic [OWED_W-1:0] owed_count,
  output logic [BANK_W-1:0] map_bank,
  output logic [ROW_W-1:0]  map_row,
  output logic [WCOL_W-1:0] map_col
);
  localparam logic [CA_W-1:0] AP_MASK = CA_W'(1) << AP_BIT;

  logic      init_issue;
  sdr_cmd_e  init_cmd;
  logic      ref_fire;
  logic [3:0] cmd_q;

  sdr_init_seq #(.DLY_W(DLY_W)) u_init (
    .clk(clk), .rst(rst), .start(init_start),
    .t_rp(t_rp), .t_mrd(t_mrd), .t_rfc(t_rfc),
    .issue(init_issue), .issue_cmd(init_cmd), .init_done(init_done)
  );

  sdr_refresh_track #(.IVL_W(IVL_W), .OWED_W(OWED_W), .DLY_W(DLY_W)) u_ref (
    .clk(clk), .rst(rst), .enable(init_done),
    .interval(refresh_interval), .lag_limit(lag_limit), .t_rfc(t_rfc),
    .grant(ref_grant), .req(ref_req), .urgent(ref_urgent), .fire(ref_fire),
    .owed(owed_count), .lag_err(lag_err)
  );

  sdr_addr_map #(.ROW_W(ROW_W), .BANK_W(BANK_W), .NCOL_W(NCOL_W)) u_map (
    .clk(clk), .rst(rst), .wide_col(wide_col), .lin_addr(lin_addr),
    .map_bank(map_bank), .map_row(map_row), .map_col(map_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= CMD_NOP;
      cmd_addr <= '0;
    end else if (init_issue) begin
      cmd_q <= init_cmd;
      case (init_cmd)
        CMD_PRE: cmd_addr <= AP_MASK;
        CMD_MRS: cmd_addr <= {{BANK_W{1'b0}}, mode_word};
        default: cmd_addr <= '0;
      endcase
    end else if (ref_fire) begin
      cmd_q    <= CMD_REF;
      cmd_addr <= '0;
    end else begin
      cmd_q    <= CMD_NOP;
      cmd_addr <= '0;
    end
  end

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;

  // R7: a granted request reaches the pins as auto-refresh
  assert_ref_after_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_grant) |=> (cmd_q == CMD_REF)) else $error("grant without refresh");

  // R5: no debt while the script has not finished
  assert_no_debt_before_init_R5: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (owed_count == '0)) else $error("debt before init");
endmodule

// File: tb/test_sdram_init_refresh_ctrl.sv
module test_sdram_init_refresh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_MRS = 4'b0000, C_REF = 4'b0001;
  localparam int TRP = 3, TMRD = 2, TRFC = 4, IVL = 20, LIM = 6;

  logic clk = 0, rst = 1, init_start = 0, ref_grant = 0, wide_col = 0;
  logic [11:0] mode_word = 12'h032;
  logic [7:0]  t_rp = TRP, t_mrd = TMRD, t_rfc = TRFC, lag_limit = LIM;
  logic [15:0] refresh_interval = IVL;
  logic [22:0] lin_addr = '0;
  logic cs_n, ras_n, cas_n, we_n, init_done, ref_req, ref_urgent, lag_err;
  logic [13:0] cmd_addr;
  logic [7:0]  owed_count;
  logic [1:0]  map_bank;
  logic [11:0] map_row;
  logic [8:0]  map_col;
  logic [3:0]  cmd;
  int cyc = 0, checks = 0, errors = 0;

  assign cmd = {cs_n, ras_n, cas_n, we_n};
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_refresh_ctrl i_sdram_init_refresh_ctrl (
    .clk(clk), .rst(rst), .init_start(init_start), .mode_word(mode_word),
    .t_rp(t_rp), .t_mrd(t_mrd), .t_rfc(t_rfc), .refresh_interval(refresh_interval),
    .lag_limit(lag_limit), .ref_grant(ref_grant), .wide_col(wide_col), .lin_addr(lin_addr),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_addr(cmd_addr), .init_done(init_done), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .lag_err(lag_err), .owed_count(owed_count),
    .map_bank(map_bank), .map_row(map_row), .map_col(map_col)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_owed_change();
    logic [7:0] o = owed_count;
    for (int i = 0; i < 400 && owed_count == o; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; ref_grant = 0;
    repeat (3) @(negedge clk); rst = 0;
  endtask

  task automatic t_reset_state();
    chk(cmd == C_NOP, "R1 cmd", cmd, C_NOP);
    chk({init_done, ref_req, ref_urgent, lag_err} == 4'b0, "R1 flags",
        {init_done, ref_req, ref_urgent, lag_err}, 0);
    chk(owed_count == 0, "R1 owed", owed_count, 0);
  endtask

  task automatic t_no_tick_before_init();
    repeat (50) @(negedge clk);
    chk(owed_count == 0 && !ref_req, "R5 idle debt", owed_count, 0);
  endtask

  task automatic t_init_sequence();
    logic [3:0]  rc [8];
    logic [13:0] ra [8];
    int rt [8];
    int n = 0, done_t = -1;
    init_start = 1; @(negedge clk); init_start = 0;
    for (int i = 0; i < 100 && done_t < 0; i++) begin
      if (i == 3) init_start = 1;
      if (i == 4) init_start = 0;
      if (cmd != C_NOP && n < 8) begin rc[n] = cmd; ra[n] = cmd_addr; rt[n] = cyc; n++; end
      if (init_done) done_t = cyc;
      if (done_t < 0) @(negedge clk);
    end
    chk(n == 4, "R2 command count / R4 restart mid-run", n, 4);
    if (n == 4) begin
      chk(rc[0] == C_PRE && ra[0] == 14'h400, "R2 precharge-all", {rc[0], ra[0]}, {C_PRE, 14'h400});
      chk(rc[1] == C_MRS && ra[1] == 14'h032, "R2 mode set", {rc[1], ra[1]}, {C_MRS, 14'h032});
      chk(rc[2] == C_REF && rc[3] == C_REF, "R2 two refreshes", {rc[2], rc[3]}, {C_REF, C_REF});
      chk(rt[1] - rt[0] == TRP, "R3 tRP spacing", rt[1] - rt[0], TRP);
      chk(rt[2] - rt[1] == TMRD, "R3 tMRD spacing", rt[2] - rt[1], TMRD);
      chk(rt[3] - rt[2] == TRFC, "R3 tRFC spacing", rt[3] - rt[2], TRFC);
      chk(done_t - rt[3] == TRFC, "R3 enable delay", done_t - rt[3], TRFC);
    end
  endtask

  task automatic t_restart_ignored();
    int seen = 0;
    init_start = 1; @(negedge clk); init_start = 0;
    repeat (15) begin
      if (cmd != C_NOP) seen++;
      @(negedge clk);
    end
    chk(seen == 0 && init_done, "R4 restart after done", seen, 0);
  endtask

  task automatic t_tick_period();
    int a, b;
    wait_owed_change(); a = cyc;
    wait_owed_change(); b = cyc;
    chk(b - a == IVL, "R6 interval", b - a, IVL);
  endtask

  task automatic t_grant();
    logic [7:0] o;
    wait_owed_change(); o = owed_count;
    chk(ref_req, "R7 request raised", ref_req, 1);
    ref_grant = 1; @(negedge clk); ref_grant = 0;
    chk(cmd == C_REF, "R7 refresh on grant", cmd, C_REF);
    chk(owed_count == o - 1, "R7 debt repaid", owed_count, o - 1);
    ref_grant = 1;
    for (int i = 0; i < 40 && owed_count != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(cmd == C_NOP && owed_count == 0, "R7 grant ignored without request",
        {cmd, owed_count}, {C_NOP, 8'd0});
    ref_grant = 0;
  endtask

  task automatic t_recovery();
    int t0 = -1, t1 = -1;
    wait_owed_change(); wait_owed_change();
    ref_grant = 1;
    for (int i = 0; i < 20 && t1 < 0; i++) begin
      @(negedge clk);
      if (cmd == C_REF) begin
        if (t0 < 0) begin
          t0 = cyc;
          chk(!ref_req, "R8 request low in recovery", ref_req, 0);
        end else t1 = cyc;
      end
    end
    ref_grant = 0;
    chk(t1 - t0 == TRFC, "R8 refresh spacing", t1 - t0, TRFC);
  endtask

  task automatic t_coincide();
    wait_owed_change();
    chk(owed_count == 1, "R9 setup debt", owed_count, 1);
    repeat (IVL - 1) @(negedge clk);
    ref_grant = 1; @(negedge clk); ref_grant = 0;
    chk(cmd == C_REF, "R9 refresh issued on tick", cmd, C_REF);
    chk(owed_count == 1, "R9 debt unchanged", owed_count, 1);
    ref_grant = 1; @(negedge clk); @(negedge clk); ref_grant = 0;
  endtask

  task automatic t_urgent_lag();
    for (int i = 0; i < 12 && owed_count != 2; i++) wait_owed_change();
    chk(!ref_urgent, "R10 below half", ref_urgent, 0);
    wait_owed_change();
    chk(ref_urgent && owed_count == 3, "R10 at half", {ref_urgent, owed_count}, {1'b1, 8'd3});
    for (int i = 0; i < 12 && owed_count != 6; i++) wait_owed_change();
    @(negedge clk);
    chk(!lag_err, "R11 at limit no error", lag_err, 0);
    wait_owed_change(); @(negedge clk);
    chk(lag_err && owed_count == 7, "R11 over limit", {lag_err, owed_count}, {1'b1, 8'd7});
    ref_grant = 1;
    for (int i = 0; i < 80 && owed_count != 0; i++) @(negedge clk);
    ref_grant = 0;
    chk(lag_err && owed_count == 0, "R11 sticky after repay", {lag_err, owed_count}, {1'b1, 8'd0});
    chk(!ref_urgent, "R10 zero debt", ref_urgent, 0);
  endtask

  task automatic t_saturate();
    refresh_interval = 16'd1;
    repeat (300) @(negedge clk);
    chk(owed_count == 8'd255, "R13 saturate", owed_count, 255);
    repeat (5) @(negedge clk);
    chk(owed_count == 8'd255, "R13 no wrap", owed_count, 255);
    refresh_interval = IVL;
  endtask

  task automatic t_addr_map();
    wide_col = 0; lin_addr = 23'h400000 | (23'd2 << 20) | (23'hABC << 8) | 23'h5D;
    @(negedge clk);
    chk({map_bank, map_row, map_col} == {2'd2, 12'hABC, 9'h05D}, "R12 narrow split",
        {map_bank, map_row, map_col}, {2'd2, 12'hABC, 9'h05D});
    wide_col = 1; lin_addr = (23'd3 << 21) | (23'h123 << 9) | 23'h1A7;
    @(negedge clk);
    chk({map_bank, map_row, map_col} == {2'd3, 12'h123, 9'h1A7}, "R12 wide split",
        {map_bank, map_row, map_col}, {2'd3, 12'h123, 9'h1A7});
  endtask

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    t_reset_state();
    t_no_tick_before_init();
    t_addr_map();
    t_init_sequence();
    t_restart_ignored();
    t_tick_period();
    t_grant();
    t_recovery();
    t_coincide();
    t_urgent_lag();
    t_saturate();
    do_reset();
    t_reset_state();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule